// File: doc/BRIEF.md
# Operand-Stage Address Sequencer with Hidden Address and Scratch Registers

This block is the operand stage of a small 16-bit processor core. An instruction arrives already decoded: an operation class, the ModRM byte and a 16-bit displacement. The block then runs a short sequence of steps over a register-file port and a word memory read port. For memory forms (mod field 00, 01 or 10) it first runs an address step and leaves the result in a hidden address register. For register forms (mod = 11) it skips that step, so the operation works from whatever the hidden registers already hold.

Two hidden registers are kept. One holds the last computed address. The other is a scratch word that memory loads and register exchanges pass through. Both are readable on observation outputs. Supported operations: load effective address, far-pointer load into DS or ES, far indirect jump, table translate, and register exchange. Undefined register forms do not fault. Instead they expose stale hidden-register contents in a repeatable way.

Top module: `opstage_top`

## Requirements
- R1: After reset the hidden address and scratch registers read 0, `ready` is 1, and `done`, `rf_we`, `mem_req` and `jmp_valid` are 0.
- R2: For a memory form, the address is base plus index plus displacement, taken modulo 2^16, and it is left in the hidden address register. The rm field selects base and index: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP, 111 BX. The displacement depends on mod: mod 00 adds none, mod 01 adds the sign-extended low byte of `disp`, and mod 10 adds all of `disp`. The combination mod 00 with rm 110 uses `disp` alone as the address. Register codes are AX 0, CX 1, DX 2, BX 3, SP 4, BP 5, SI 6, DI 7, ES 8 and DS 11.
- R3: When mod = 11, no address step runs and the hidden address register keeps its previous value.
- R4: Load effective address (op 0) writes the hidden address register's value, after any address step, into the register named by the ModRM reg field.
- R5: A far-pointer load (op 1 for DS, op 2 for ES) reads the word at the hidden address and puts it into the reg-field register and into the scratch register. It then reads the word at the hidden address plus 2 and puts it into DS (code 11) or ES (code 8). A register form does the same two reads at the stale address.
- R6: The far jump (op 3) in memory form reads the offset at the hidden address and the segment at the hidden address plus 2. It leaves the offset in the scratch register and pulses `jmp_valid` with that segment and offset.
- R7: The far jump in register form makes no memory read. It pulses `jmp_valid` with the hidden address register as segment and the scratch register as offset.
- R8: Translate (op 4) forms BX plus AL zero-extended to 16 bits and stores that address in the hidden address register. It reads one word there and writes the word's low byte into AL with byte enable 01, so AH is left unchanged.
- R9: Exchange (op 5) copies the rm register into the scratch register, then writes the rm register with the reg-field register and the reg-field register with the scratch value. The mod field is ignored and the hidden address register is unchanged. ModRM C0 (AX with AX) changes no register but loads the scratch register with AX.
- R10: Each accepted `start` gives exactly one single-cycle `done` pulse. `ready` is low from the cycle after acceptance until the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction start, taken when `ready` is 1 |
| op | input | 3 | Operation class (0 LEA, 1 LDS, 2 LES, 3 far jump, 4 translate, 5 exchange) |
| modrm | input | 8 | ModRM byte: mod [7:6], reg [5:3], rm [2:0] |
| disp | input | 16 | Displacement or direct address |
| ready | output | 1 | Idle, can take a start |
| done | output | 1 | Single-cycle completion pulse |
| rf_rsel | output | 4 | Register-file read select |
| rf_rdata | input | 16 | Register-file read data, same cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_wsel | output | 4 | Register-file write select |
| rf_wdata | output | 16 | Register-file write data |
| rf_wbe | output | 2 | Byte enables for the write (bit 0 low byte) |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 16 | Byte address of the word read |
| mem_rdata | input | 16 | Read data, valid the cycle after the request |
| jmp_valid | output | 1 | Far jump target valid |
| jmp_seg | output | 16 | Jump segment |
| jmp_off | output | 16 | Jump offset |
| obs_ind | output | 16 | Hidden address register |
| obs_tmp | output | 16 | Hidden scratch register |

## Verification
The bench builds the block with its default segment-word offset of 2, so both words of each far pointer fall at addresses that can be computed by hand. The instruction stream runs back to back with no reset between instructions. Register forms therefore pick up address and scratch values that earlier memory forms left behind. Translate is given an AL with bit 7 set, which tells zero extension apart from sign extension, and it runs while AH is nonzero.

// File: rtl/opstage_pkg.sv
package opstage_pkg;
  localparam int WORD_W = 16;
  localparam int SEL_W  = 4;

  localparam logic [SEL_W-1:0] R_AX = 4'd0;
  localparam logic [SEL_W-1:0] R_BX = 4'd3;
  localparam logic [SEL_W-1:0] R_BP = 4'd5;
  localparam logic [SEL_W-1:0] R_SI = 4'd6;
  localparam logic [SEL_W-1:0] R_DI = 4'd7;
  localparam logic [SEL_W-1:0] R_ES = 4'd8;
  localparam logic [SEL_W-1:0] R_DS = 4'd11;

  typedef enum logic [2:0] {
    OP_LEA  = 3'd0,
    OP_LDS  = 3'd1,
    OP_LES  = 3'd2,
    OP_JMPF = 3'd3,
    OP_XLAT = 3'd4,
    OP_XCHG = 3'd5
  } op_e;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } rsrc_t;

  function automatic logic is_mem_form(input logic [1:0] md);
    return md != 2'b11;
  endfunction

  function automatic rsrc_t ea_base(input logic [1:0] md, input logic [2:0] rm);
    rsrc_t r;
    r.en = 1'b1;
    case (rm)
      3'b000, 3'b001, 3'b111: r.sel = R_BX;
      3'b010, 3'b011:         r.sel = R_BP;
      3'b100:                 r.sel = R_SI;
      3'b101:                 r.sel = R_DI;
      default: begin
        r.sel = R_BP;
        r.en  = (md != 2'b00);
      end
    endcase
    return r;
  endfunction

  function automatic rsrc_t ea_index(input logic [2:0] rm);
    rsrc_t r;
    case (rm)
      3'b000, 3'b010: begin r.en = 1'b1; r.sel = R_SI; end
      3'b001, 3'b011: begin r.en = 1'b1; r.sel = R_DI; end
      default:        begin r.en = 1'b0; r.sel = R_AX; end
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] ea_disp(input logic [1:0] md,
                                                input logic [2:0] rm,
                                                input logic [WORD_W-1:0] d);
    case (md)
      2'b00:   return (rm == 3'b110) ? d : '0;
      2'b01:   return {{(WORD_W-8){d[7]}}, d[7:0]};
      2'b10:   return d;
      default: return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] xlat_addr(input logic [WORD_W-1:0] bx,
                                                  input logic [7:0] al);
    return bx + {{(WORD_W-8){1'b0}}, al};
  endfunction
endpackage

// File: rtl/opstage_hidden.sv
module opstage_hidden
  import opstage_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ind_we,
  input  logic [WORD_W-1:0] ind_d,
  input  logic              tmp_we,
  input  logic [WORD_W-1:0] tmp_d,
  output logic [WORD_W-1:0] ind_q,
  output logic [WORD_W-1:0] tmp_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ind_q <= '0;
      tmp_q <= '0;
    end else begin
      if (ind_we) ind_q <= ind_d;
      if (tmp_we) tmp_q <= tmp_d;
    end
  end
endmodule

// File: rtl/opstage_ea.sv
module opstage_ea
  import opstage_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_phase,
  input  logic              idx_phase,
  input  logic [1:0]        md,
  input  logic [2:0]        rm,
  input  logic [WORD_W-1:0] disp,
  input  logic [WORD_W-1:0] rf_rdata,
  output logic [SEL_W-1:0]  ea_rsel,
  output logic [WORD_W-1:0] ea_sum
);
  rsrc_t             base_src;
  rsrc_t             idx_src;
  logic [WORD_W-1:0] acc_q;

  assign base_src = ea_base(md, rm);
  assign idx_src  = ea_index(rm);
  assign ea_rsel  = idx_phase ? idx_src.sel : base_src.sel;

  always_ff @(posedge clk) begin
    if (!rst_n)          acc_q <= '0;
    else if (base_phase) acc_q <= base_src.en ? rf_rdata : '0;
  end

  assign ea_sum = acc_q + (idx_src.en ? rf_rdata : '0) + ea_disp(md, rm, disp);
endmodule

// File: rtl/opstage_ctrl.sv
module opstage_ctrl
  import opstage_pkg::*;
#(
  parameter int unsigned SEG_OFFSET = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [7:0]        modrm,
  input  logic [WORD_W-1:0] disp,
  output logic              ready,
  output logic              done,
  output logic [SEL_W-1:0]  rf_rsel,
  input  logic [WORD_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [SEL_W-1:0]  rf_wsel,
  output logic [WORD_W-1:0] rf_wdata,
  output logic [1:0]        rf_wbe,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              jmp_valid,
  output logic [WORD_W-1:0] jmp_seg,
  output logic [WORD_W-1:0] jmp_off,
  input  logic [WORD_W-1:0] ind_q,
  input  logic [WORD_W-1:0] tmp_q,
  output logic              ind_we,
  output logic [WORD_W-1:0] ind_d,
  output logic              tmp_we,
  output logic [WORD_W-1:0] tmp_d,
  output logic              base_phase,
  output logic              idx_phase,
  output logic [1:0]        md_q,
  output logic [2:0]        rm_q,
  output logic [WORD_W-1:0] disp_q,
  input  logic [SEL_W-1:0]  ea_rsel,
  input  logic [WORD_W-1:0] ea_sum
);
  typedef enum logic [3:0] {
    S_IDLE, S_EA_B, S_EA_I, S_LEA_W, S_MEM0, S_MEM1, S_MEM2, S_JREG,
    S_XL_A, S_XL_B, S_XL_M, S_XL_W, S_XC_1, S_XC_2, S_XC_3, S_NOP
  } st_e;

  localparam logic [WORD_W-1:0] SEG_STEP = WORD_W'(SEG_OFFSET);

  st_e        st_q, st_d;
  logic [2:0] op_q;
  logic [2:0] reg_q;
  logic [7:0] al_q;
  logic       ea_load;
  logic       xlat_wr;

  function automatic st_e after_ea(input logic [2:0] o, input logic [1:0] md);
    case (o)
      OP_LEA:          return S_LEA_W;
      OP_LDS, OP_LES:  return S_MEM0;
      OP_JMPF:         return is_mem_form(md) ? S_MEM0 : S_JREG;
      default:         return S_NOP;
    endcase
  endfunction

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (start) begin
        if (op == OP_XLAT)             st_d = S_XL_A;
        else if (op == OP_XCHG)        st_d = S_XC_1;
        else if (op > OP_XCHG)         st_d = S_NOP;
        else if (is_mem_form(modrm[7:6])) st_d = S_EA_B;
        else                           st_d = after_ea(op, modrm[7:6]);
      end
      S_EA_B:  st_d = S_EA_I;
      S_EA_I:  st_d = after_ea(op_q, md_q);
      S_MEM0:  st_d = S_MEM1;
      S_MEM1:  st_d = S_MEM2;
      S_XL_A:  st_d = S_XL_B;
      S_XL_B:  st_d = S_XL_M;
      S_XL_M:  st_d = S_XL_W;
      S_XC_1:  st_d = S_XC_2;
      S_XC_2:  st_d = S_XC_3;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= '0;
      md_q   <= '0;
      reg_q  <= '0;
      rm_q   <= '0;
      disp_q <= '0;
      al_q   <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && start) begin
        op_q   <= op;
        md_q   <= modrm[7:6];
        reg_q  <= modrm[5:3];
        rm_q   <= modrm[2:0];
        disp_q <= disp;
      end
      if (st_q == S_XL_A) al_q <= rf_rdata[7:0];
    end
  end

  assign ready      = (st_q == S_IDLE);
  assign base_phase = (st_q == S_EA_B);
  assign idx_phase  = (st_q == S_EA_I);
  assign ea_load    = idx_phase;

  always_comb begin
    done      = 1'b0;
    rf_rsel   = R_AX;
    rf_we     = 1'b0;
    rf_wsel   = R_AX;
    rf_wdata  = '0;
    rf_wbe    = 2'b11;
    mem_req   = 1'b0;
    mem_addr  = ind_q;
    jmp_valid = 1'b0;
    jmp_seg   = '0;
    jmp_off   = '0;
    ind_we    = 1'b0;
    ind_d     = ea_sum;
    tmp_we    = 1'b0;
    tmp_d     = mem_rdata;
    case (st_q)
      S_EA_B: rf_rsel = ea_rsel;
      S_EA_I: begin
        rf_rsel = ea_rsel;
        ind_we  = 1'b1;
      end
      S_LEA_W: begin
        rf_we    = 1'b1;
        rf_wsel  = {1'b0, reg_q};
        rf_wdata = ind_q;
        done     = 1'b1;
      end
      S_MEM0: mem_req = 1'b1;
      S_MEM1: begin
        mem_req  = 1'b1;
        mem_addr = ind_q + SEG_STEP;
        tmp_we   = 1'b1;
        if (op_q != OP_JMPF) begin
          rf_we    = 1'b1;
          rf_wsel  = {1'b0, reg_q};
          rf_wdata = mem_rdata;
        end
      end
      S_MEM2: begin
        done = 1'b1;
        if (op_q == OP_JMPF) begin
          jmp_valid = 1'b1;
          jmp_seg   = mem_rdata;
          jmp_off   = tmp_q;
        end else begin
          rf_we    = 1'b1;
          rf_wsel  = (op_q == OP_LDS) ? R_DS : R_ES;
          rf_wdata = mem_rdata;
        end
      end
      S_JREG: begin
        done      = 1'b1;
        jmp_valid = 1'b1;
        jmp_seg   = ind_q;
        jmp_off   = tmp_q;
      end
      S_XL_A: rf_rsel = R_AX;
      S_XL_B: begin
        rf_rsel = R_BX;
        ind_we  = 1'b1;
        ind_d   = xlat_addr(rf_rdata, al_q);
      end
      S_XL_M: mem_req = 1'b1;
      S_XL_W: begin
        rf_we    = 1'b1;
        rf_wsel  = R_AX;
        rf_wbe   = 2'b01;
        rf_wdata = {{(WORD_W-8){1'b0}}, mem_rdata[7:0]};
        done     = 1'b1;
      end
      S_XC_1: begin
        rf_rsel = {1'b0, rm_q};
        tmp_we  = 1'b1;
        tmp_d   = rf_rdata;
      end
      S_XC_2: begin
        rf_rsel  = {1'b0, reg_q};
        rf_we    = 1'b1;
        rf_wsel  = {1'b0, rm_q};
        rf_wdata = rf_rdata;
      end
      S_XC_3: begin
        rf_we    = 1'b1;
        rf_wsel  = {1'b0, reg_q};
        rf_wdata = tmp_q;
        done     = 1'b1;
      end
      S_NOP: done = 1'b1;
      default: ;
    endcase
  end

  assign xlat_wr = rf_we && (op_q == OP_XLAT);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R10
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready) else $error("ready after accept"); // R10
  AST_NO_EA_REGFORM: assert property (@(posedge clk) disable iff (!rst_n)
    ea_load |-> md_q != 2'b11) else $error("address step on register form"); // R3
  AST_XLAT_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_wr |-> (rf_wbe == 2'b01 && rf_wsel == R_AX)) else $error("translate write"); // R8
endmodule

// File: rtl/opstage_top.sv
module opstage_top
  import opstage_pkg::*;
#(
  parameter int unsigned SEG_OFFSET = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [7:0]  modrm,
  input  logic [15:0] disp,
  output logic        ready,
  output logic        done,
  output logic [3:0]  rf_rsel,
  input  logic [15:0] rf_rdata,
  output logic        rf_we,
  output logic [3:0]  rf_wsel,
  output logic [15:0] rf_wdata,
  output logic [1:0]  rf_wbe,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic [15:0] mem_rdata,
  output logic        jmp_valid,
  output logic [15:0] jmp_seg,
  output logic [15:0] jmp_off,
  output logic [15:0] obs_ind,
  output logic [15:0] obs_tmp
);
  logic              ind_we, tmp_we;
  logic [WORD_W-1:0] ind_d, tmp_d, ind_q, tmp_q;
  logic              base_phase, idx_phase;
  logic [1:0]        md_q;
  logic [2:0]        rm_q;
  logic [WORD_W-1:0] disp_q, ea_sum;
  logic [SEL_W-1:0]  ea_rsel;

  opstage_ctrl #(.SEG_OFFSET(SEG_OFFSET)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .modrm(modrm), .disp(disp),
    .ready(ready), .done(done), .rf_rsel(rf_rsel), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata), .rf_wbe(rf_wbe),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .jmp_valid(jmp_valid), .jmp_seg(jmp_seg), .jmp_off(jmp_off),
    .ind_q(ind_q), .tmp_q(tmp_q), .ind_we(ind_we), .ind_d(ind_d),
    .tmp_we(tmp_we), .tmp_d(tmp_d), .base_phase(base_phase), .idx_phase(idx_phase),
    .md_q(md_q), .rm_q(rm_q), .disp_q(disp_q), .ea_rsel(ea_rsel), .ea_sum(ea_sum)
  );

  opstage_ea u_ea (
    .clk(clk), .rst_n(rst_n), .base_phase(base_phase), .idx_phase(idx_phase),
    .md(md_q), .rm(rm_q), .disp(disp_q), .rf_rdata(rf_rdata),
    .ea_rsel(ea_rsel), .ea_sum(ea_sum)
  );

  opstage_hidden u_hidden (
    .clk(clk), .rst_n(rst_n), .ind_we(ind_we), .ind_d(ind_d),
    .tmp_we(tmp_we), .tmp_d(tmp_d), .ind_q(ind_q), .tmp_q(tmp_q)
  );

  assign obs_ind = ind_q;
  assign obs_tmp = tmp_q;

  AST_JUMP_IS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_valid |-> done) else $error("jump without done"); // R6
  AST_READ_NEAR_IND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr == ind_q || mem_addr == ind_q + WORD_W'(SEG_OFFSET)))
    else $error("read away from hidden address"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!rf_we && !mem_req && !jmp_valid)) else $error("activity while idle"); // R1
endmodule

// File: tb/opstage_top_test.sv
module opstage_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [7:0]  modrm = '0;
  logic [15:0] disp = '0;
  logic        ready, done, rf_we, mem_req, jmp_valid;
  logic [3:0]  rf_rsel, rf_wsel;
  logic [15:0] rf_rdata, rf_wdata, mem_addr, jmp_seg, jmp_off, obs_ind, obs_tmp;
  logic [15:0] mem_rdata = '0;
  logic [1:0]  rf_wbe;

  int checks = 0;
  int errors = 0;
  int nreads = 0;
  logic        jhit = 1'b0;
  logic [15:0] jseg_c = '0, joff_c = '0;
  logic [15:0] rf [0:15];

  always #5 clk = ~clk;

  opstage_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .modrm(modrm), .disp(disp),
    .ready(ready), .done(done), .rf_rsel(rf_rsel), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata), .rf_wbe(rf_wbe),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .jmp_valid(jmp_valid), .jmp_seg(jmp_seg), .jmp_off(jmp_off),
    .obs_ind(obs_ind), .obs_tmp(obs_tmp)
  );

  assign rf_rdata = rf[rf_rsel];

  always @(posedge clk) begin
    if (rf_we) begin
      if (rf_wbe[0]) rf[rf_wsel][7:0]  <= rf_wdata[7:0];
      if (rf_wbe[1]) rf[rf_wsel][15:8] <= rf_wdata[15:8];
    end
    if (mem_req) begin
      mem_rdata <= mem_addr ^ 16'hC3C3;
      nreads = nreads + 1;
    end
    if (jmp_valid) begin
      jhit   = 1'b1;
      jseg_c = jmp_seg;
      joff_c = jmp_off;
    end
  end

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  modrm;
    logic [15:0] disp;
    logic [15:0] e_ind;
    logic [15:0] e_tmp;
    logic [3:0]  s1;
    logic [15:0] v1;
    logic [3:0]  s2;
    logic [15:0] v2;
    logic        jchk;
    logic [15:0] jseg;
    logic [15:0] joff;
    logic [1:0]  nrd;
  } vec_t;

  // Memory word at byte address a is a ^ C3C3. Registers start AX 0012, CX 1111,
  // DX 2222, BX 1000, SP 3000, BP 2000, SI 0100, DI 0200.
  localparam vec_t VEC [17] = '{
    '{3'd0, 8'h08, 16'h7777, 16'h1100, 16'h0000, 4'd1, 16'h1100, 4'd6, 16'h0100, 1'b0, 16'h0, 16'h0, 2'd0}, // R2 R4 BX+SI
    '{3'd0, 8'h56, 16'h55F0, 16'h1FF0, 16'h0000, 4'd2, 16'h1FF0, 4'd5, 16'h2000, 1'b0, 16'h0, 16'h0, 2'd0}, // R2 BP-16
    '{3'd0, 8'hA5, 16'h0034, 16'h0234, 16'h0000, 4'd4, 16'h0234, 4'd7, 16'h0200, 1'b0, 16'h0, 16'h0, 2'd0}, // R2 DI+d16
    '{3'd0, 8'h26, 16'h4321, 16'h4321, 16'h0000, 4'd4, 16'h4321, 4'd0, 16'h0012, 1'b0, 16'h0, 16'h0, 2'd0}, // R2 direct
    '{3'd0, 8'hD0, 16'h0000, 16'h4321, 16'h0000, 4'd2, 16'h4321, 4'd1, 16'h1100, 1'b0, 16'h0, 16'h0, 2'd0}, // R3 R4 stale
    '{3'd1, 8'h4F, 16'h0002, 16'h1002, 16'hD3C1, 4'd1, 16'hD3C1, 4'd11, 16'hD3C7, 1'b0, 16'h0, 16'h0, 2'd2}, // R5 DS
    '{3'd2, 8'hD0, 16'h0000, 16'h1002, 16'hD3C1, 4'd2, 16'hD3C1, 4'd8, 16'hD3C7, 1'b0, 16'h0, 16'h0, 2'd2}, // R5 ES stale
    '{3'd3, 8'hAB, 16'h0010, 16'h2210, 16'hE1D3, 4'd5, 16'h2000, 4'd7, 16'h0200, 1'b1, 16'hE1D1, 16'hE1D3, 2'd2}, // R6
    '{3'd5, 8'hC0, 16'h0000, 16'h2210, 16'h0012, 4'd0, 16'h0012, 4'd3, 16'h1000, 1'b0, 16'h0, 16'h0, 2'd0}, // R9 AX,AX
    '{3'd3, 8'hE8, 16'h0000, 16'h2210, 16'h0012, 4'd0, 16'h0012, 4'd1, 16'hD3C1, 1'b1, 16'h2210, 16'h0012, 2'd0}, // R7
    '{3'd4, 8'h00, 16'h0000, 16'h1012, 16'h0012, 4'd0, 16'h00D1, 4'd3, 16'h1000, 1'b0, 16'h0, 16'h0, 2'd1}, // R8
    '{3'd5, 8'hCB, 16'h0000, 16'h1012, 16'h1000, 4'd1, 16'h1000, 4'd3, 16'hD3C1, 1'b0, 16'h0, 16'h0, 2'd0}, // R9 CX,BX
    '{3'd5, 8'h19, 16'h0000, 16'h1012, 16'h1000, 4'd1, 16'hD3C1, 4'd3, 16'h1000, 1'b0, 16'h0, 16'h0, 2'd0}, // R9 mod 00
    '{3'd4, 8'h00, 16'h0000, 16'h10D1, 16'h1000, 4'd0, 16'h0012, 4'd3, 16'h1000, 1'b0, 16'h0, 16'h0, 2'd1}, // R8 AL bit7
    '{3'd0, 8'h44, 16'h3380, 16'h0080, 16'h1000, 4'd0, 16'h0080, 4'd6, 16'h0100, 1'b0, 16'h0, 16'h0, 2'd0}, // R2 SI-128
    '{3'd0, 8'h82, 16'hFFFF, 16'h20FF, 16'h1000, 4'd0, 16'h20FF, 4'd5, 16'h2000, 1'b0, 16'h0, 16'h0, 2'd0}, // R2 wrap
    '{3'd4, 8'h00, 16'h0000, 16'h10FF, 16'h1000, 4'd0, 16'h203C, 4'd3, 16'h1000, 1'b0, 16'h0, 16'h0, 2'd1}  // R8 AH kept
  };

  function automatic string tag_of(input logic [2:0] o, input logic [7:0] m);
    case (o)
      3'd0:    return (m[7:6] == 2'b11) ? "R3/R4" : "R2/R4";
      3'd1, 3'd2: return "R5";
      3'd3:    return (m[7:6] == 2'b11) ? "R7" : "R6";
      3'd4:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    string t;
    int n;
    v = VEC[i];
    t = tag_of(v.op, v.modrm);
    @(negedge clk);
    jhit = 1'b0;
    nreads = 0;
    start = 1'b1; op = v.op; modrm = v.modrm; disp = v.disp;
    @(negedge clk);
    start = 1'b0;
    check("R10", "ready low while busy", {15'd0, ready}, 16'd0);
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    check("R10", "done seen", {15'd0, done}, 16'd1);
    @(negedge clk);
    check("R10", "done one cycle", {15'd0, done}, 16'd0);
    check("R10", "ready after done", {15'd0, ready}, 16'd1);
    check(t, $sformatf("v%0d hidden address", i), obs_ind, v.e_ind);
    check(t, $sformatf("v%0d scratch", i), obs_tmp, v.e_tmp);
    check(t, $sformatf("v%0d reg %0d", i, v.s1), rf[v.s1], v.v1);
    check(t, $sformatf("v%0d reg %0d", i, v.s2), rf[v.s2], v.v2);
    check(t, $sformatf("v%0d memory reads", i), 16'(nreads), {14'd0, v.nrd});
    check(t, $sformatf("v%0d jump pulse", i), {15'd0, jhit}, {15'd0, v.jchk});
    if (v.jchk) begin
      check(t, $sformatf("v%0d jump segment", i), jseg_c, v.jseg);
      check(t, $sformatf("v%0d jump offset", i), joff_c, v.joff);
    end
  endtask

  initial begin
    for (int k = 0; k < 16; k++) rf[k] = '0;
    rf[0] = 16'h0012; rf[1] = 16'h1111; rf[2] = 16'h2222; rf[3] = 16'h1000;
    rf[4] = 16'h3000; rf[5] = 16'h2000; rf[6] = 16'h0100; rf[7] = 16'h0200;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset hidden address", obs_ind, 16'h0000);
    check("R1", "reset scratch", obs_tmp, 16'h0000);
    check("R1", "reset ready", {15'd0, ready}, 16'd1);
    check("R1", "reset idle outputs", {12'd0, done, rf_we, mem_req, jmp_valid}, 16'd0);
    for (int i = 0; i < 17; i++) run_vec(i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule